// File: doc/BRIEF.md
# Flash Busy-Status Overlay Unit

This unit sits on the read return path of a flash memory model and reports the progress of an internal write or erase. While the command decoder reports an operation as running, the unit replaces two bits of every byte the host reads with status bits. The top bit gives a polling value: the inverse of the byte being written during a write, and zero during an erase. The next bit flips on every separate read strobe, so a host can tell that the part is still busy by comparing two reads in a row. The low bits pass through from the array path unchanged. Once the operation ends, the read path returns plain array data.

The unit also drives an active-low busy pin. This pin drops a fixed number of clock cycles after the decoder accepts the last write of a command, provided the operation is still running then. It rises again when the operation ends or is put on hold. The toggle bit advances only on a falling read strobe seen while the chip is selected. It does not move while an erase is on hold.

Top module: `flash_status_reporter`

## Requirements
- R1: With `opBusy` low, `readData` equals `arrayData` in every bit.
- R2: With `opBusy` high and `opErase` low, `readData[7]` is the inverse of `lastData[7]`.
- R3: With `opBusy` and `opErase` both high, `readData[7]` is 0, including while `opSuspended` is high.
- R4: With `opBusy` high and `opSuspended` low, `readData[6]` changes value one cycle after each clock edge at which `oeN` is sampled low, having been sampled high at the edge before, while `ceN` is sampled low.
- R5: `readData[6]` keeps its value when no such falling read strobe occurs, including strobes made with `ceN` high.
- R6: While `opSuspended` is high, read strobes do not change `readData[6]`.
- R7: With `opBusy` high, `readData[5:0]` equals `arrayData[5:0]`.
- R8: If `cmdAccept` is sampled high at edge k and not again, `readyBusy` is low from edge k+BUSY_DELAY (default 3) on, provided `opBusy` is high at that edge and `opSuspended` is low.
- R9: `readyBusy` is high one edge after `opBusy` is sampled low, and high whenever `opSuspended` is high.
- R10: During and after reset, `readyBusy` is high, and the toggle bit starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opBusy | input | 1 | Internal write or erase is running |
| opErase | input | 1 | The running operation is an erase |
| opSuspended | input | 1 | The erase is on hold |
| cmdAccept | input | 1 | One-cycle pulse: last command write accepted |
| lastData | input | 8 | Byte being written |
| arrayData | input | 8 | Byte from the array read path |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Read strobe, active low |
| readData | output | 8 | Byte returned to the host |
| readyBusy | output | 1 | Low while busy, high when ready |

## Verification
The hardest case to reach is a mix of read strobes with the chip both selected and deselected, spread across the start of the busy period, a hold and a resume. In that case the toggle bit must stay in step while the busy pin changes on its own delay. The stimulus keeps a write busy across the arming delay while it issues strobes with `ceN` high. It then holds an erase in the middle of a series of strobes, and it fires a second `cmdAccept` while the first count is still running. A behavioural model in the bench predicts every output bit on every cycle.

// File: rtl/statrep_pkg.sv
package statrep_pkg;
  typedef struct packed {
    logic flipToggle;
    logic busyHold;
  } strobe_t;
endpackage

// File: rtl/statrep_ctrl.sv
module statrep_ctrl import statrep_pkg::*; #(
  parameter int BUSY_DELAY = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    opBusy,
  input  logic    opSuspended,
  input  logic    cmdAccept,
  input  logic    ceN,
  input  logic    oeN,
  output strobe_t strb
);
  localparam int CNT_W = $clog2(BUSY_DELAY + 1);

  logic             oePrev;
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             expire;

  assign expire = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oePrev <= 1'b1;
      cnt    <= '0;
      armed  <= 1'b0;
    end else begin
      oePrev <= oeN;
      if (cmdAccept)        cnt <= CNT_W'(BUSY_DELAY);
      else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
      armed <= expire ? opBusy : (armed & opBusy);
    end
  end

  always_comb begin
    strb.flipToggle = oePrev & ~oeN & ~ceN & opBusy & ~opSuspended;
    strb.busyHold   = armed;
  end

  // R8
  arm_on_expire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expire && opBusy) |=> strb.busyHold);
  // R9
  idle_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opBusy |=> !strb.busyHold);
endmodule

// File: rtl/statrep_dpath.sv
module statrep_dpath import statrep_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic          opBusy,
  input  logic          opErase,
  input  logic          opSuspended,
  input  logic [DW-1:0] lastData,
  input  logic [DW-1:0] arrayData,
  output logic [DW-1:0] readData,
  output logic          readyBusy
);
  localparam int POLL_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;

  logic toggleQ;

  always_ff @(posedge clk) begin
    if (!rstN)                toggleQ <= 1'b0;
    else if (strb.flipToggle) toggleQ <= ~toggleQ;
  end

  always_comb begin
    readData = arrayData;
    if (opBusy) begin
      readData[POLL_BIT] = opErase ? 1'b0 : ~lastData[POLL_BIT];
      readData[TOG_BIT]  = toggleQ;
    end
    readyBusy = ~(strb.busyHold & ~opSuspended);
  end

  // R5
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.flipToggle |=> $stable(toggleQ));
  // R6
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    opSuspended |=> $stable(toggleQ));
endmodule

// File: rtl/flash_status_reporter.sv
module flash_status_reporter import statrep_pkg::*; #(
  parameter int DW         = 8,
  parameter int BUSY_DELAY = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          opBusy,
  input  logic          opErase,
  input  logic          opSuspended,
  input  logic          cmdAccept,
  input  logic [DW-1:0] lastData,
  input  logic [DW-1:0] arrayData,
  input  logic          ceN,
  input  logic          oeN,
  output logic [DW-1:0] readData,
  output logic          readyBusy
);
  strobe_t strb;

  statrep_ctrl #(.BUSY_DELAY(BUSY_DELAY)) ctrl_i (
    .clk(clk), .rstN(rstN), .opBusy(opBusy), .opSuspended(opSuspended),
    .cmdAccept(cmdAccept), .ceN(ceN), .oeN(oeN), .strb(strb));

  statrep_dpath #(.DW(DW)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .opBusy(opBusy), .opErase(opErase),
    .opSuspended(opSuspended), .lastData(lastData), .arrayData(arrayData),
    .readData(readData), .readyBusy(readyBusy));

  // R9
  ready_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opBusy |=> readyBusy);
  // R6
  susp_bit_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opBusy && opSuspended && $past(opBusy && opSuspended)) |-> $stable(readData[DW-2]));
endmodule

// File: tb/flash_status_reporter_tb_top.sv
module flash_status_reporter_tb_top;
  localparam int DLY = 3;
  logic clk = 0, rstN = 0;
  logic opBusy = 0, opErase = 0, opSuspended = 0, cmdAccept = 0;
  logic [7:0] lastData = 8'h00, arrayData = 8'h00;
  logic ceN = 1, oeN = 1;
  logic [7:0] readData;
  logic readyBusy;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_status_reporter #(.DW(8), .BUSY_DELAY(DLY)) dut_i (.*);

  // behavioural reference
  int mCnt = 0;
  bit mArmed = 0, mTog = 0, mOePrev = 1;
  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mArmed = 0; mTog = 0; mOePrev = 1;
    end else begin
      if (mOePrev && !oeN && !ceN && opBusy && !opSuspended) mTog = !mTog;
      mOePrev = oeN;
      mArmed = (mCnt == 1) ? opBusy : (mArmed && opBusy);
      if (cmdAccept) mCnt = DLY; else if (mCnt > 0) mCnt--;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    bit expRdy;
    expRdy = !(mArmed && !opSuspended);
    chk("R8/R9/R10 readyBusy", readyBusy, expRdy);
    if (!opBusy) chk("R1 passthrough", readData, arrayData);
    else begin
      chk(opErase ? "R3 erase poll" : "R2 write poll", readData[7],
          opErase ? 0 : !lastData[7]);
      chk("R4/R5/R6 toggle", readData[6], mTog);
      chk("R7 low bits", readData[5:0], arrayData[5:0]);
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic strobe(bit sel);
    ceN = !sel; oeN = 0; step(2); oeN = 1; ceN = 1; step(2);
  endtask

  initial begin : watchdog
    #400000;
    if (!done) begin
      fails++; done = 1;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit b0, b1;
    step(3);
    // R10 explicit reset-state check
    chk("R10 reset ready", readyBusy, 1);
    rstN = 1; arrayData = 8'h3C; step(3);
    // R1 idle strobes do not disturb
    strobe(1); arrayData = 8'hC5; step(2);
    // R2 write with bit7 low, R8 delay
    lastData = 8'h5A; arrayData = 8'h2B; cmdAccept = 1; opBusy = 1; step(1);
    cmdAccept = 0;
    step(DLY - 1);
    chk("R8 still ready before delay", readyBusy, 1);
    step(1);
    chk("R8 busy after delay", readyBusy, 0);
    b0 = readData[6];
    strobe(0); // R5 deselected strobe
    chk("R5 no toggle when deselected", readData[6], b0);
    strobe(1);
    chk("R4 toggled", readData[6], !b0);
    strobe(1); strobe(1);
    // write done, array returns true data
    opBusy = 0; arrayData = 8'h5A; step(1);
    chk("R9 ready after done", readyBusy, 1);
    step(2);
    // R2 write with bit7 high, re-accept mid-count
    lastData = 8'h81; arrayData = 8'h7E; opBusy = 1; cmdAccept = 1; step(1);
    cmdAccept = 0; step(1); cmdAccept = 1; step(1); cmdAccept = 0;
    step(DLY); strobe(1); opBusy = 0; step(3);
    // R3 erase with hold and resume
    opErase = 1; opBusy = 1; lastData = 8'hFF; arrayData = 8'h11; cmdAccept = 1; step(1);
    cmdAccept = 0; step(DLY + 1);
    strobe(1); strobe(1);
    opSuspended = 1; step(1);
    chk("R9 ready while held", readyBusy, 1);
    b1 = readData[6];
    strobe(1); strobe(1); strobe(1);
    chk("R6 held toggle", readData[6], b1);
    opSuspended = 0; step(1);
    chk("R8 busy again on resume", readyBusy, 0);
    strobe(1);
    chk("R4 toggles after resume", readData[6], !b1);
    opBusy = 0; opErase = 0; arrayData = 8'hFF; step(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule